// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state changes a processor core makes when it enters an exception handler. The core raises a single-cycle request carrying a 5-bit cause code, the program counter of the instruction that was executing, and the live status word. On the next clock edge the block presents the new status word, a register-file write of the return address, updated saved-status, cause and translation-fault registers, and the address the fetch unit must redirect to.

Behaviour depends on the exception-handling flag (EH) in the incoming status. With EH clear, the context is saved and, when a memory-management unit is configured, EH is set. With EH set, the context is left alone. A translation miss taken while EH is set is treated as a nested (double) miss and is sent to the general handler rather than the fast miss handler. Each cause class sets its own combination of translation-fault flags: data-side, permission, bad-address, double-miss and write-enable.

Status layout: bit 0 PIE (previous interrupt enable), bit 1 U (user mode), bit 2 EH, bits [9:4] CRS (current register set), bits [15:10] PRS (previous register set), and all other bits are passed through. Translation-fault register layout: bit 0 D, bit 1 PERM, bit 2 BAD, bit 3 DBL, bit 4 WE.

Top module: `exc_entry_seq`

## Requirements
- R1: Reset clears every output to zero. A request asserted in one cycle produces `entry_vld` high for exactly the following cycle. In that cycle `pc_o` holds the handler target.
- R2: When EH is clear, the request writes `cur_pc + 4` (modulo 2^32) to the register file in the following cycle. The destination is index 30 for a break (cause 7) and index 29 for any other cause. When EH is set, no register-file write occurs.
- R3: The new status equals the old status with CRS, PIE and U cleared. Every other bit is kept unless R4 or R5 changes it.
- R4: When EH is clear, the old status is copied into `bstatus_o` for a break and into `estatus_o` otherwise, and PRS is loaded from the old CRS. When EH is set, both saved-status registers and PRS keep their values.
- R5: When EH is clear and `mmu_present` is high, the new status has EH set. When EH is clear and `mmu_present` is low, EH stays clear.
- R6: For any cause other than break, `exccause_o` becomes the cause code placed at bits [6:2], with all other bits zero. A break leaves `exccause_o` unchanged.
- R7: A translation miss (cause 14 = fetch miss, cause 15 = data miss) with EH clear redirects to `FAST_VEC`. Every other case redirects to `GEN_VEC`.
- R8: When EH is clear and `mmu_present` is high, the translation-fault register has D, PERM, BAD and DBL cleared, then the cause's flags ORed in. WE and bits 31:5 keep their values.
- R9: Cause flags are as follows. A miss sets WE, plus D for cause 15. A permission fault sets PERM, plus D for a read (17) or write (18) fault but not for an execute fault (16). The miss and permission classes also set WE. A supervisor-address or misaligned fault sets BAD, plus D for the data variants (supervisor data address 13, misaligned data 8) but not for supervisor fetch address 12 or misaligned destination 9. All other causes set no flag.
- R10: A miss taken with EH set clears D, PERM and BAD, sets DBL, and sets D again for a data miss. This write happens regardless of `mmu_present`, and WE is kept.
- R11: With EH set, any cause that is not a miss leaves the translation-fault register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_cause | input | 5 | Cause code |
| cur_pc | input | 32 | PC of the executing instruction |
| cur_status | input | 32 | Live status word |
| mmu_present | input | 1 | Configuration: memory-management unit fitted |
| entry_vld | output | 1 | Entry committed this cycle |
| pc_o | output | 32 | Handler address to fetch from |
| status_o | output | 32 | New status word |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Return address |
| estatus_o | output | 32 | Saved status for exceptions |
| bstatus_o | output | 32 | Saved status for breaks |
| exccause_o | output | 32 | Exception cause register |
| tlbmisc_o | output | 32 | Translation-fault flag register |

## Verification
The cause codes are applied in a sequence that alternates EH-clear and EH-set status words. Because the translation-fault register carries state from one entry to the next, this separates flags that are cleared from flags that are kept (WE survives; D, PERM, BAD and DBL do not). Status words with CRS values of zero, mid-range and all ones show whether PRS is loaded from CRS or left alone, and a set high half shows that pass-through bits are kept. A break placed between other causes shows that the cause register is held and that the break-specific save registers are used, and a PC at the top of the address space shows that the return address wraps.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int          DW       = 32,
  parameter int          RF_AW    = 5,
  parameter int          CW       = 5,
  parameter logic [31:0] GEN_VEC  = 32'h1000_0020,
  parameter logic [31:0] FAST_VEC = 32'h1000_0100,
  parameter int          EA_IDX   = 29,
  parameter int          BA_IDX   = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_req,
  input  logic [CW-1:0]    exc_cause,
  input  logic [DW-1:0]    cur_pc,
  input  logic [DW-1:0]    cur_status,
  input  logic             mmu_present,
  output logic             entry_vld,
  output logic [DW-1:0]    pc_o,
  output logic [DW-1:0]    status_o,
  output logic             rf_we,
  output logic [RF_AW-1:0] rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic [DW-1:0]    estatus_o,
  output logic [DW-1:0]    bstatus_o,
  output logic [DW-1:0]    exccause_o,
  output logic [DW-1:0]    tlbmisc_o
);

  localparam int ST_PIE = 0;
  localparam int ST_U   = 1;
  localparam int ST_EH  = 2;
  localparam int RS_W   = 6;
  localparam int CRS_LO = 4;
  localparam int PRS_LO = CRS_LO + RS_W;
  localparam int CAUSE_LO = 2;

  localparam logic [DW-1:0] TM_D    = DW'(1) << 0;
  localparam logic [DW-1:0] TM_PERM = DW'(1) << 1;
  localparam logic [DW-1:0] TM_BAD  = DW'(1) << 2;
  localparam logic [DW-1:0] TM_DBL  = DW'(1) << 3;
  localparam logic [DW-1:0] TM_WE   = DW'(1) << 4;
  localparam logic [DW-1:0] TM_CLR  = TM_D | TM_PERM | TM_BAD | TM_DBL;

  localparam logic [CW-1:0] C_BRK     = CW'(7);
  localparam logic [CW-1:0] C_MIS_D   = CW'(8);
  localparam logic [CW-1:0] C_MIS_DST = CW'(9);
  localparam logic [CW-1:0] C_SUP_I   = CW'(12);
  localparam logic [CW-1:0] C_SUP_D   = CW'(13);
  localparam logic [CW-1:0] C_MISS_I  = CW'(14);
  localparam logic [CW-1:0] C_MISS_D  = CW'(15);
  localparam logic [CW-1:0] C_PERM_X  = CW'(16);
  localparam logic [CW-1:0] C_PERM_R  = CW'(17);
  localparam logic [CW-1:0] C_PERM_W  = CW'(18);

  logic          eh, is_brk, is_miss;
  logic [DW-1:0] flags, st_new, tm_next, ret_addr;

  assign eh       = cur_status[ST_EH];
  assign is_brk   = exc_cause == C_BRK;
  assign is_miss  = (exc_cause == C_MISS_I) || (exc_cause == C_MISS_D);
  assign ret_addr = cur_pc + DW'(4);

  always_comb begin
    flags = '0;
    case (exc_cause)
      C_MISS_D:            flags = TM_D | TM_WE;
      C_MISS_I:            flags = TM_WE;
      C_PERM_R, C_PERM_W:  flags = TM_D | TM_PERM | (eh ? '0 : TM_WE);
      C_PERM_X:            flags = TM_PERM | (eh ? '0 : TM_WE);
      C_SUP_D, C_MIS_D:    flags = TM_D | TM_BAD;
      C_SUP_I, C_MIS_DST:  flags = TM_BAD;
      default:             flags = '0;
    endcase
  end

  always_comb begin
    st_new = cur_status;
    st_new[CRS_LO +: RS_W] = '0;
    st_new[ST_PIE] = 1'b0;
    st_new[ST_U]   = 1'b0;
    if (!eh) begin
      st_new[PRS_LO +: RS_W] = cur_status[CRS_LO +: RS_W];
      if (mmu_present) st_new[ST_EH] = 1'b1;
    end
  end

  always_comb begin
    tm_next = tlbmisc_o;
    if (is_miss && eh)
      tm_next = (tlbmisc_o & ~(TM_D | TM_PERM | TM_BAD)) | TM_DBL
                | ((exc_cause == C_MISS_D) ? TM_D : '0);
    else if (!eh && mmu_present)
      tm_next = (tlbmisc_o & ~TM_CLR) | flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_vld  <= 1'b0;
      pc_o       <= '0;
      status_o   <= '0;
      rf_we      <= 1'b0;
      rf_waddr   <= '0;
      rf_wdata   <= '0;
      estatus_o  <= '0;
      bstatus_o  <= '0;
      exccause_o <= '0;
      tlbmisc_o  <= '0;
    end else begin
      entry_vld <= exc_req;
      rf_we     <= exc_req && !eh;
      if (exc_req) begin
        pc_o      <= (is_miss && !eh) ? FAST_VEC : GEN_VEC;
        status_o  <= st_new;
        rf_waddr  <= is_brk ? RF_AW'(BA_IDX) : RF_AW'(EA_IDX);
        rf_wdata  <= ret_addr;
        tlbmisc_o <= tm_next;
        if (!eh) begin
          if (is_brk) bstatus_o <= cur_status;
          else        estatus_o <= cur_status;
        end
        if (!is_brk) exccause_o <= DW'(exc_cause) << CAUSE_LO;
      end
    end
  end

  AST_ENTRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld |-> $past(exc_req)); // R1
  AST_RA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && !cur_status[ST_EH] |=> rf_we && rf_wdata == $past(cur_pc) + DW'(4)); // R2
  AST_NO_RF_EH: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && cur_status[ST_EH] |=> !rf_we); // R2
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld |-> status_o[CRS_LO +: RS_W] == '0 && !status_o[ST_PIE] && !status_o[ST_U]); // R3
  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && cur_status[ST_EH] |=> $stable(estatus_o) && $stable(bstatus_o)); // R4
  AST_BRK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && exc_cause == C_BRK |=> $stable(exccause_o)); // R6
  AST_FAST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && is_miss && !cur_status[ST_EH] |=> pc_o == FAST_VEC); // R7
  AST_DBL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && is_miss && cur_status[ST_EH] |=> tlbmisc_o[3] && pc_o == GEN_VEC); // R10
  AST_EH_KEEP_TM: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && !is_miss && cur_status[ST_EH] |=> $stable(tlbmisc_o)); // R11

endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  localparam logic [31:0] GEN  = 32'h1000_0020;
  localparam logic [31:0] FAST = 32'h1000_0100;
  localparam int NV = 12;
  localparam logic [31:0] SA = 32'hA000_0053;
  localparam logic [31:0] SB = 32'h0000_0C37;
  localparam logic [31:0] SC = 32'h0000_0001;
  localparam logic [31:0] SD = 32'h0000_03F2;

  // {cause, mmu, status, pc, exp_pc, exp_status, exp_tlbmisc}
  localparam logic [165:0] VEC [NV] = '{
    {5'd15, 1'b1, SA, 32'h0000_4000, FAST, 32'hA000_1404, 32'h11},
    {5'd14, 1'b1, SB, 32'h0000_4100, GEN,  32'h0000_0C04, 32'h18},
    {5'd17, 1'b1, SC, 32'h0000_4200, GEN,  32'h0000_0004, 32'h13},
    {5'd13, 1'b1, SC, 32'h0000_4300, GEN,  32'h0000_0004, 32'h15},
    {5'd9,  1'b1, SC, 32'h0000_4400, GEN,  32'h0000_0004, 32'h14},
    {5'd16, 1'b1, SB, 32'h0000_4500, GEN,  32'h0000_0C04, 32'h14},
    {5'd7,  1'b1, SA, 32'h8000_0000, GEN,  32'hA000_1404, 32'h10},
    {5'd15, 1'b0, SC, 32'h0000_4700, FAST, 32'h0000_0000, 32'h10},
    {5'd8,  1'b1, SD, 32'h0000_4800, GEN,  32'h0000_FC04, 32'h15},
    {5'd2,  1'b1, SC, 32'hFFFF_FFFC, GEN,  32'h0000_0004, 32'h10},
    {5'd18, 1'b1, SC, 32'h0000_4A00, GEN,  32'h0000_0004, 32'h13},
    {5'd15, 1'b1, SB, 32'h0000_4B00, GEN,  32'h0000_0C04, 32'h19}
  };

  logic clk = 1'b0, rst_n = 1'b0, exc_req = 1'b0, mmu_present = 1'b0;
  logic [4:0]  exc_cause = '0;
  logic [31:0] cur_pc = '0, cur_status = '0;
  logic        entry_vld, rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] pc_o, status_o, rf_wdata, estatus_o, bstatus_o, exccause_o, tlbmisc_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
    .cur_pc(cur_pc), .cur_status(cur_status), .mmu_present(mmu_present),
    .entry_vld(entry_vld), .pc_o(pc_o), .status_o(status_o), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .estatus_o(estatus_o),
    .bstatus_o(bstatus_o), .exccause_o(exccause_o), .tlbmisc_o(tlbmisc_o));

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] x_est, x_bst, x_cause;
    x_est = '0; x_bst = '0; x_cause = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset entry_vld", 32'(entry_vld), 0);
    chk("R1", "reset pc_o", pc_o, 0);
    chk("R1", "reset status_o", status_o, 0);
    chk("R1", "reset tlbmisc_o", tlbmisc_o, 0);
    chk("R2", "reset rf_we", 32'(rf_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle entry_vld", 32'(entry_vld), 0);

    for (int i = 0; i < NV; i++) begin
      logic [4:0]  c;
      logic        m, eh;
      logic [31:0] st, pc, xpc, xst, xtm;
      {c, m, st, pc, xpc, xst, xtm} = VEC[i];
      eh = st[2];
      exc_req = 1'b1; exc_cause = c; mmu_present = m; cur_status = st; cur_pc = pc;
      @(negedge clk);
      exc_req = 1'b0;
      if (!eh) begin
        if (c == 5'd7) x_bst = st; else x_est = st;
      end
      if (c != 5'd7) x_cause = {25'b0, c, 2'b00};
      chk("R1", $sformatf("v%0d entry_vld", i), 32'(entry_vld), 1);
      chk("R7", $sformatf("v%0d target", i), pc_o, xpc);
      chk("R3", $sformatf("v%0d status R4 R5", i), status_o, xst);
      chk((c == 5'd14 || c == 5'd15) && eh ? "R10" : (eh ? "R11" : "R9"),
          $sformatf("v%0d tlbmisc R8", i), tlbmisc_o, xtm);
      chk("R2", $sformatf("v%0d rf_we", i), 32'(rf_we), 32'(!eh));
      if (!eh) begin
        chk("R2", $sformatf("v%0d rf_waddr", i), 32'(rf_waddr), (c == 5'd7) ? 30 : 29);
        chk("R2", $sformatf("v%0d rf_wdata", i), rf_wdata, pc + 32'd4);
      end
      chk("R4", $sformatf("v%0d estatus", i), estatus_o, x_est);
      chk("R4", $sformatf("v%0d bstatus", i), bstatus_o, x_bst);
      chk("R6", $sformatf("v%0d exccause", i), exccause_o, x_cause);
      @(negedge clk);
      chk("R1", $sformatf("v%0d pulse ends", i), 32'(entry_vld), 0);
    end

    // R5: EH set with no MMU keeps EH; EH clear with no MMU stays clear
    exc_req = 1'b1; exc_cause = 5'd3; mmu_present = 1'b0; cur_status = SB; cur_pc = 32'h100;
    @(negedge clk); exc_req = 1'b0;
    chk("R5", "EH kept, no MMU", status_o, 32'h0000_0C04);
    exc_req = 1'b1; cur_status = SD;
    @(negedge clk); exc_req = 1'b0;
    chk("R5", "EH stays clear, no MMU", status_o, 32'h0000_FC00);
    chk("R8", "tlbmisc untouched without MMU", tlbmisc_o, 32'h19);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "reset again tlbmisc", tlbmisc_o, 0);
    chk("R1", "reset again estatus", estatus_o, 0);
    finish_run();
  end
endmodule